// File: doc/BRIEF.md
# Vectored Peripheral Interrupt Aggregator

The block gathers a group of peripheral interrupt request pulses into one or more independent aggregation units and reports, for each unit, the most urgent request. Each unit holds a pending bit for every source. It forms a vector index from the winning source number. It also builds a vector address from a programmable upper field and that index, so the processor can jump straight to the service routine.

A per-source route bit decides which of two service paths a pending request takes. A cleared bit sends it to the standard interrupt path. A set bit sends it to a server path that a separate transfer engine consumes. When the engine reports completion, the block clears that pending bit and sets a per-source done-request bit. The done-request bit then raises a standard interrupt for the same source, so software can close out the transfer.

All units share one register port. A write strobe, an address and write data program the route bits, the done-request bits and the vector base. Reads return data combinationally from the addressed register.

Top module: `irq_vector_hub`

## Requirements
- R1: After reset all route, done-request, pending and base state is zero, every `irq_o` and `srv_req_o` bit is low, and every index output reads 0.
- R2: A one-cycle pulse on a request input sets that source's pending bit at the next rising clock edge. A pending source whose route bit is 0 then drives `irq_o` high. While no source is active on the standard path, `irq_o` is low and the index is 0. The standard path stays asserted until it is acknowledged or its state is rewritten through the register port.
- R3: A source is active on the standard path when it is (pending and routed standard) or its done-request bit is set. `vec_idx_o` gives the lowest-numbered active source, and reading register offset 3 returns the same value.
- R4: `vec_addr_o` equals {base[BASE_W-1:0], index, 1'b0}, so that vectors are 2-byte aligned.
- R5: A pending source whose route bit is 1 raises `srv_req_o` and does not raise `irq_o`. `srv_idx_o` gives the lowest-numbered such source, or 0 when there is none.
- R6: A `srv_done_i` pulse while `srv_req_o` is high clears the pending bit of the source named by `srv_idx_o` and sets its done-request bit. `irq_o` is high on the next cycle.
- R7: An `ack_i` pulse while `irq_o` is high clears both the pending bit and the done-request bit of the reported source and leaves the other sources unchanged. An `ack_i` pulse while `irq_o` is low has no effect.
- R8: When a request pulse and a clear (acknowledge or completion) hit the same pending bit in the same cycle, the bit stays set.
- R9: Writing offset 1 clears each done-request bit whose write-data bit is 1. A hardware set of a done-request bit in the same cycle wins over the clear.
- R10: Units are independent. Register writes, requests, acknowledges and completions aimed at one unit change no other unit's state or outputs.
- R11: Register map per unit, with address = {unit, offset}: offset 0 is the route bits (read/write), offset 1 the done-request bits, offset 2 the vector base (read/write, only the low BASE_W bits are stored and the upper bits read 0), offset 3 the index (read only). Writes to offset 3 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register address {unit, offset[1:0]} |
| wdata_i | input | DATA_W | Register write data |
| rdata_o | output | DATA_W | Read data of the addressed register |
| req_i | input | N_UNITS*N_SRC | Request pulses, unit u in bits [u*N_SRC +: N_SRC] |
| ack_i | input | N_UNITS | Standard interrupt acknowledge per unit |
| srv_done_i | input | N_UNITS | Server completion pulse per unit |
| irq_o | output | N_UNITS | Standard interrupt request per unit |
| vec_idx_o | output | N_UNITS*IDX_W | Winning standard source per unit |
| vec_addr_o | output | N_UNITS*VEC_W | Vector address per unit |
| srv_req_o | output | N_UNITS | Server request per unit |
| srv_idx_o | output | N_UNITS*IDX_W | Winning server source per unit |

## Verification
The bench builds the block with two units of eight sources, a 10-bit base and 16-bit data. Eight sources cover the full 3-bit index range, including source 7 and the wrap of the priority search. Two units make cross-unit isolation observable. A 10-bit base inside a 16-bit data word shows that the upper write bits are dropped. Directed phases set up the collisions between requests, acknowledges, completions and clear-writes. A long random phase then compares every output against a behavioural model on every cycle.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
  typedef enum logic [1:0] {
    REG_ROUTE = 2'd0,
    REG_DONE  = 2'd1,
    REG_BASE  = 2'd2,
    REG_INDEX = 2'd3
  } reg_off_e;
endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int N     = 8,
  parameter int IDX_W = 3
) (
  input  logic [N-1:0]     vec_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             any_o
);
  // lowest index wins; zero when empty
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IDX_W'(i);
    end
  end

  assign any_o = |vec_i;
endmodule

// File: rtl/irq_unit.sv
module irq_unit import irq_hub_pkg::*; #(
  parameter int N_SRC  = 8,
  parameter int IDX_W  = 3,
  parameter int BASE_W = 10,
  parameter int DATA_W = 16,
  localparam int VEC_W = BASE_W + IDX_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  reg_off_e          off_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [N_SRC-1:0]  req_i,
  input  logic              ack_i,
  input  logic              srv_done_i,
  output logic              irq_o,
  output logic [IDX_W-1:0]  vec_idx_o,
  output logic [VEC_W-1:0]  vec_addr_o,
  output logic              srv_req_o,
  output logic [IDX_W-1:0]  srv_idx_o
);
  logic [N_SRC-1:0]  pend_q, done_q, route_q;
  logic [BASE_W-1:0] base_q;
  logic [N_SRC-1:0]  std_act, srv_act, ack_clr, done_set, w1c;
  logic [N_SRC-1:0]  pend_d, done_d;
  logic [IDX_W-1:0]  std_idx, srv_idx;
  logic              std_any, srv_any;

  assign std_act = (pend_q & ~route_q) | done_q;
  assign srv_act = pend_q & route_q;

  irq_prio_enc #(.N(N_SRC), .IDX_W(IDX_W)) i_std_enc (
    .vec_i(std_act), .idx_o(std_idx), .any_o(std_any)
  );

  irq_prio_enc #(.N(N_SRC), .IDX_W(IDX_W)) i_srv_enc (
    .vec_i(srv_act), .idx_o(srv_idx), .any_o(srv_any)
  );

  always_comb begin
    ack_clr  = '0;
    done_set = '0;
    w1c      = '0;
    if (ack_i && std_any)        ack_clr[std_idx]  = 1'b1;
    if (srv_done_i && srv_any)   done_set[srv_idx] = 1'b1;
    if (wr_i && off_i == REG_DONE) w1c = wdata_i[N_SRC-1:0];
  end

  // sets dominate clears
  assign pend_d = (pend_q & ~ack_clr & ~done_set) | req_i;
  assign done_d = (done_q & ~ack_clr & ~w1c) | done_set;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= '0;
      done_q  <= '0;
      route_q <= '0;
      base_q  <= '0;
    end else begin
      pend_q <= pend_d;
      done_q <= done_d;
      if (wr_i && off_i == REG_ROUTE) route_q <= wdata_i[N_SRC-1:0];
      if (wr_i && off_i == REG_BASE)  base_q  <= wdata_i[BASE_W-1:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (off_i)
      REG_ROUTE: rdata_o = DATA_W'(route_q);
      REG_DONE:  rdata_o = DATA_W'(done_q);
      REG_BASE:  rdata_o = DATA_W'(base_q);
      REG_INDEX: rdata_o = DATA_W'(std_idx);
      default:   rdata_o = '0;
    endcase
  end

  assign irq_o      = std_any;
  assign vec_idx_o  = std_idx;
  assign vec_addr_o = {base_q, std_idx, 1'b0};
  assign srv_req_o  = srv_any;
  assign srv_idx_o  = srv_idx;
endmodule

// File: rtl/irq_vector_hub.sv
module irq_vector_hub import irq_hub_pkg::*; #(
  parameter int N_UNITS = 2,
  parameter int N_SRC   = 8,
  parameter int BASE_W  = 10,
  parameter int DATA_W  = 16,
  localparam int IDX_W  = (N_SRC > 1) ? $clog2(N_SRC) : 1,
  localparam int UNIT_W = (N_UNITS > 1) ? $clog2(N_UNITS) : 1,
  localparam int ADDR_W = UNIT_W + 2,
  localparam int VEC_W  = BASE_W + IDX_W + 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_en_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [DATA_W-1:0]        wdata_i,
  output logic [DATA_W-1:0]        rdata_o,
  input  logic [N_UNITS*N_SRC-1:0] req_i,
  input  logic [N_UNITS-1:0]       ack_i,
  input  logic [N_UNITS-1:0]       srv_done_i,
  output logic [N_UNITS-1:0]       irq_o,
  output logic [N_UNITS*IDX_W-1:0] vec_idx_o,
  output logic [N_UNITS*VEC_W-1:0] vec_addr_o,
  output logic [N_UNITS-1:0]       srv_req_o,
  output logic [N_UNITS*IDX_W-1:0] srv_idx_o
);
  logic [UNIT_W-1:0] unit_sel;
  reg_off_e          off;
  logic [DATA_W-1:0] unit_rdata [N_UNITS];

  assign unit_sel = addr_i[ADDR_W-1:2];
  assign off      = reg_off_e'(addr_i[1:0]);

  for (genvar u = 0; u < N_UNITS; u++) begin : g_unit
    logic wr_u;
    assign wr_u = wr_en_i && (unit_sel == UNIT_W'(u));

    irq_unit #(
      .N_SRC(N_SRC), .IDX_W(IDX_W), .BASE_W(BASE_W), .DATA_W(DATA_W)
    ) i_unit (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_i       (wr_u),
      .off_i      (off),
      .wdata_i    (wdata_i),
      .rdata_o    (unit_rdata[u]),
      .req_i      (req_i[u*N_SRC +: N_SRC]),
      .ack_i      (ack_i[u]),
      .srv_done_i (srv_done_i[u]),
      .irq_o      (irq_o[u]),
      .vec_idx_o  (vec_idx_o[u*IDX_W +: IDX_W]),
      .vec_addr_o (vec_addr_o[u*VEC_W +: VEC_W]),
      .srv_req_o  (srv_req_o[u]),
      .srv_idx_o  (srv_idx_o[u*IDX_W +: IDX_W])
    );
  end

  always_comb begin
    rdata_o = '0;
    for (int u = 0; u < N_UNITS; u++) begin
      if (unit_sel == UNIT_W'(u)) rdata_o = unit_rdata[u];
    end
  end
endmodule

// File: rtl/irq_vector_hub_chk.sv
module irq_vector_hub_chk #(
  parameter int N_UNITS = 2,
  parameter int N_SRC   = 8,
  parameter int IDX_W   = 3
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     wr_en_i,
  input logic [N_UNITS*N_SRC-1:0] req_i,
  input logic [N_UNITS-1:0]       ack_i,
  input logic [N_UNITS-1:0]       srv_done_i,
  input logic [N_UNITS-1:0]       irq_o,
  input logic [N_UNITS*IDX_W-1:0] vec_idx_o,
  input logic [N_UNITS-1:0]       srv_req_o,
  input logic [N_UNITS*IDX_W-1:0] srv_idx_o
);
  for (genvar u = 0; u < N_UNITS; u++) begin : g_chk
    logic [IDX_W-1:0] idx, sidx;
    logic [N_SRC-1:0] rq;
    logic             rq_at_idx;
    assign idx       = vec_idx_o[u*IDX_W +: IDX_W];
    assign sidx      = srv_idx_o[u*IDX_W +: IDX_W];
    assign rq        = req_i[u*N_SRC +: N_SRC];
    assign rq_at_idx = rq[idx];

    AST_IDLE_ZERO_IDX: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !irq_o[u] |-> idx == '0) else $error("idle index"); // R2

    AST_STD_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o[u] && !ack_i[u] && !wr_en_i |=> irq_o[u]) else $error("irq dropped"); // R2

    AST_ACK_RETIRES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ack_i[u] && irq_o[u] && !rq_at_idx && !srv_done_i[u]
      |=> !irq_o[u] || idx != $past(idx)) else $error("ack ignored"); // R7

    AST_SRV_IDLE_IDX: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !srv_req_o[u] |-> sidx == '0) else $error("srv idle index"); // R5

    AST_DONE_RAISES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      srv_req_o[u] && srv_done_i[u] |=> irq_o[u]) else $error("done no irq"); // R6
  end
endmodule

bind irq_vector_hub irq_vector_hub_chk #(
  .N_UNITS(N_UNITS), .N_SRC(N_SRC), .IDX_W(IDX_W)
) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .req_i(req_i),
  .ack_i(ack_i), .srv_done_i(srv_done_i), .irq_o(irq_o),
  .vec_idx_o(vec_idx_o), .srv_req_o(srv_req_o), .srv_idx_o(srv_idx_o)
);

// File: tb/test_irq_vector_hub.sv
`timescale 1ns/1ps
module test_irq_vector_hub;
  localparam int NU = 2, NS = 8, BW = 10, DW = 16, IW = 3, VW = 14;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [2:0]    addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic [NU*NS-1:0] req = '0;
  logic [NU-1:0] ack = '0, done = '0;
  logic [NU-1:0] irq, srv_req;
  logic [NU*IW-1:0] vidx, sidx;
  logic [NU*VW-1:0] vaddr;

  int checks = 0, fails = 0;
  string tag = "R1";

  always #4 clk = ~clk;

  irq_vector_hub #(.N_UNITS(NU), .N_SRC(NS), .BASE_W(BW), .DATA_W(DW)) i_irq_vector_hub (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .req_i(req), .ack_i(ack), .srv_done_i(done), .irq_o(irq),
    .vec_idx_o(vidx), .vec_addr_o(vaddr), .srv_req_o(srv_req), .srv_idx_o(sidx)
  );

  // behavioural reference
  bit [NS-1:0] m_pend [NU];
  bit [NS-1:0] m_done [NU];
  bit [NS-1:0] m_route[NU];
  bit [BW-1:0] m_base [NU];

  function automatic int lowest(bit [NS-1:0] v);
    for (int i = 0; i < NS; i++) if (v[i]) return i;
    return 0;
  endfunction

  function automatic bit [NS-1:0] std_set(int u);
    return (m_pend[u] & ~m_route[u]) | m_done[u];
  endfunction

  always @(posedge clk) begin
    if (rst_n) begin
      for (int u = 0; u < NU; u++) begin
        bit [NS-1:0] a, s, np, nd;
        int wi, si;
        a = std_set(u); s = m_pend[u] & m_route[u];
        wi = lowest(a); si = lowest(s);
        np = m_pend[u]; nd = m_done[u];
        if (ack[u] && a != 0) begin np[wi] = 1'b0; nd[wi] = 1'b0; end
        if (done[u] && s != 0) np[si] = 1'b0;
        if (wr_en && addr[2] == u[0] && addr[1:0] == 2'd1) nd = nd & ~wdata[NS-1:0];
        if (done[u] && s != 0) nd[si] = 1'b1;
        np = np | req[u*NS +: NS];
        if (wr_en && addr[2] == u[0] && addr[1:0] == 2'd0) m_route[u] = wdata[NS-1:0];
        if (wr_en && addr[2] == u[0] && addr[1:0] == 2'd2) m_base[u] = wdata[BW-1:0];
        m_pend[u] = np; m_done[u] = nd;
      end
    end
  end

  task automatic chk(string t, string what, int u, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s unit%0d %s act=%0h exp=%0h", t, u, what, act, exp);
    end
  endtask

  task automatic compare_all();
    for (int u = 0; u < NU; u++) begin
      bit [NS-1:0] a, s;
      int wi;
      a = std_set(u); s = m_pend[u] & m_route[u]; wi = lowest(a);
      chk(tag, "irq R2", u, irq[u], (a != 0));
      chk(tag, "idx R3", u, vidx[u*IW +: IW], wi);
      chk(tag, "addr R4", u, vaddr[u*VW +: VW], {m_base[u], wi[IW-1:0], 1'b0});
      chk(tag, "srv_req R5", u, srv_req[u], (s != 0));
      chk(tag, "srv_idx R5", u, sidx[u*IW +: IW], lowest(s));
    end
    begin
      int u; longint e;
      u = addr[2];
      case (addr[1:0])
        2'd0: e = m_route[u];
        2'd1: e = m_done[u];
        2'd2: e = m_base[u];
        default: e = lowest(std_set(u));
      endcase
      chk(tag, "rdata R11", u, rdata, e);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    compare_all();
    req = '0; ack = '0; done = '0; wr_en = 1'b0;
  endtask

  task automatic wr(bit [2:0] a, bit [DW-1:0] d);
    wr_en = 1'b1; addr = a; wdata = d; step();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int u = 0; u < NU; u++) begin
      m_pend[u] = '0; m_done[u] = '0; m_route[u] = '0; m_base[u] = '0;
    end
    repeat (3) @(negedge clk);
    tag = "R1"; compare_all();
    chk("R1", "irq reset", 0, irq, 0);
    rst_n = 1'b1;
    for (int a = 0; a < 8; a++) begin addr = 3'(a); step(); end

    tag = "R2"; req[5] = 1'b1; step();
    chk("R2", "irq after pulse", 0, irq[0], 1);
    chk("R2", "idx", 0, vidx[2:0], 5);

    tag = "R3"; req[6] = 1'b1; req[2] = 1'b1; addr = 3'd3; step();
    chk("R3", "lowest wins", 0, vidx[2:0], 2);
    chk("R3", "index reg", 0, rdata, 2);

    tag = "R4"; wr(3'd2, 16'h03A5);
    chk("R4", "vec addr", 0, vaddr[VW-1:0], {10'h3A5, 3'd2, 1'b0});

    tag = "R7"; ack[0] = 1'b1; step();
    chk("R7", "next winner", 0, vidx[2:0], 5);
    ack[0] = 1'b1; step(); ack[0] = 1'b1; step();
    chk("R7", "idle after acks", 0, irq[0], 0);
    ack[0] = 1'b1; step();
    chk("R7", "ack when idle ignored", 0, vidx[2:0], 0);

    tag = "R8"; req[3] = 1'b1; step();
    ack[0] = 1'b1; req[3] = 1'b1; step();
    chk("R8", "set wins over ack", 0, irq[0], 1);
    ack[0] = 1'b1; step();

    tag = "R5"; wr(3'd0, 16'h0030);
    req[4] = 1'b1; req[5] = 1'b1; step();
    chk("R5", "srv req", 0, srv_req[0], 1);
    chk("R5", "no std irq", 0, irq[0], 0);
    chk("R5", "srv idx", 0, sidx[2:0], 4);

    tag = "R6"; done[0] = 1'b1; addr = 3'd1; step();
    chk("R6", "done raises irq", 0, irq[0], 1);
    chk("R6", "done bit", 0, rdata, 16'h0010);
    chk("R6", "srv moves on", 0, sidx[2:0], 5);

    tag = "R9"; wr(3'd1, 16'h0010);
    chk("R9", "w1c cleared", 0, rdata, 0);
    done[0] = 1'b1; wr(3'd1, 16'h0020);
    chk("R9", "hw set wins", 0, rdata, 16'h0020);
    ack[0] = 1'b1; step();

    tag = "R10"; req[9] = 1'b1; wr(3'd4, 16'h00FF); addr = 3'd4; step();
    chk("R10", "unit1 route", 1, rdata, 16'h00FF);
    chk("R10", "unit0 untouched irq", 0, irq[0], 0);
    chk("R10", "unit1 srv idx", 1, sidx[5:3], 1);

    tag = "R11"; wr(3'd6, 16'hFFFF);
    chk("R11", "base upper bits", 1, rdata, 16'h03FF);
    wr(3'd7, 16'h0005);
    chk("R11", "index read only", 1, rdata, 0);

    tag = "R10";
    for (int n = 0; n < 600; n++) begin
      req   = NU*NS'($urandom & $urandom & $urandom);
      ack   = NU'($urandom);
      done  = NU'($urandom);
      addr  = 3'($urandom);
      wdata = DW'($urandom);
      wr_en = ($urandom_range(0, 7) == 0);
      step();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule